// File: doc/BRIEF.md
# Nibble-to-Word Packet Datapath

This block sits between a physical-layer device that moves data four bits at a time and a packet buffer memory that is sixteen bits wide. It converts in both directions. On the receive side, nibbles that arrive while the frame signal is high are packed into sixteen-bit words. Each finished word is held in a staging register, and a write request goes out with the current receive address. On the transmit side, a packet is given by a first and a last buffer address. The block reads those words one at a time and sends each one out as four nibbles, with no gap between them.

Neither side issues its memory access on demand. Each one raises a request and waits for a grant, which comes from a shared time-slot arbiter outside the block. A word takes four nibble clocks to build or to send, so each side needs one memory slot in every four clocks. The transmit side fetches the next word while the current one is being sent. The receive frame signal comes from another clock domain, so it is synchronized before use. The received nibbles pass through a delay line of the same length, so they stay aligned with the frame signal.

Top module: `nwd_top`

## Requirements
- R1: While reset is asserted, and after it is released with no stimulus, rx_wr_req, tx_rd_req, tx_en and rx_overflow are low, and rx_wr_addr and tx_rd_addr are zero.
- R2: rx_frame and rx_nib pass through a two-stage synchronizer. When rx_frame is high on every edge from the one that samples the first nibble onward, rx_wr_req rises just after the sixth clock edge that counts from that edge, the sampling edge being the first.
- R3: Received nibbles fill a word in order. The first nibble goes to bits [3:0], the second to [7:4], the third to [11:8] and the fourth to [15:12].
- R4: A pending write holds rx_wr_req, rx_wr_addr and rx_wr_data steady until it is granted. Each granted write advances rx_wr_addr by one. Words that arrive back to back and are granted in a slot once every four clocks cause no overflow.
- R5: A word that completes while an earlier word is still waiting, with no grant on that edge, is dropped. The waiting word is kept, and rx_overflow goes high and stays high.
- R6: If rx_frame falls part way through a word, the partial nibbles are discarded. The next frame starts again at bits [3:0].
- R7: A pulse on rx_load copies rx_base into the receive address, clears rx_overflow and cancels any pending write.
- R8: A pulse on tx_load starts reads at tx_first. tx_rd_addr advances by one for each granted read and holds while a request waits. Reads stop after tx_last has been read, which leaves tx_rd_addr at tx_last+1.
- R9: Each word read is sent on tx_nib with tx_en high, bits [3:0] first and bits [15:12] last.
- R10: If every read is granted within four clocks of its request rising, the nibbles of a packet leave on consecutive clocks with no gap.
- R11: Once the last nibble of a packet has been sent, tx_en and tx_rd_req stay low until the next tx_load.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Nibble clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| rx_frame | input | 1 | Receive frame active, asynchronous to clk |
| rx_nib | input | 4 | Received nibble |
| rx_load | input | 1 | Load the receive start address |
| rx_base | input | 16 | Receive start address |
| rx_wr_grant | input | 1 | Write slot granted |
| rx_wr_req | output | 1 | Write request |
| rx_wr_addr | output | 16 | Write address |
| rx_wr_data | output | 16 | Write data word |
| rx_overflow | output | 1 | Sticky flag for a dropped receive word |
| tx_load | input | 1 | Start a transmit packet |
| tx_first | input | 16 | First word address of the packet |
| tx_last | input | 16 | Last word address of the packet |
| tx_rd_grant | input | 1 | Read slot granted; tx_rd_data is valid in the same cycle |
| tx_rd_data | input | 16 | Read data word |
| tx_rd_req | output | 1 | Read request |
| tx_rd_addr | output | 16 | Read address |
| tx_nib | output | 4 | Transmit nibble |
| tx_en | output | 1 | Transmit nibble valid |

## Verification
The assertions rely on three things about the inputs. Read data is valid in the same cycle as its grant. rx_frame and rx_nib change together, and only on whole-nibble boundaries. For the no-gap property, a read grant comes within four clocks of its request. The stimulus meets all three with a four-phase slot rotation, in which receive and transmit each own one phase. Grants are only ever given to a request that is raised. Receive grants can be turned off for a while to force a write to wait and to cause an overflow.

// File: rtl/nwd_pkg.sv
`timescale 1ns/1ps
package nwd_pkg;
  parameter int NWD_NIB_W  = 4;
  parameter int NWD_WORD_W = 16;
  parameter int NWD_ADDR_W = 16;
  parameter int NWD_SYNC   = 2;
endpackage

// File: rtl/nwd_delay_line.sv
`timescale 1ns/1ps
module nwd_delay_line #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_head
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= d;
    end else begin : g_tail
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= '0;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nwd_addr_ctr.sv
`timescale 1ns/1ps
module nwd_addr_ctr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  output logic [AW-1:0] q
);
  logic [AW-1:0] q_n;
  logic          en;

  always_comb begin
    en  = load || inc;
    q_n = load ? load_val : q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)  q <= '0;
    else if (en) q <= q_n;

  // R4 and R8: one step per accepted access
  p_addr_step_r4_r8: assert property (@(posedge clk) disable iff (!rst_n)
    inc && !load |=> q == $past(q) + 1'b1);
  p_addr_load_r7_r8: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> q == $past(load_val));
endmodule

// File: rtl/nwd_rx.sv
`timescale 1ns/1ps
module nwd_rx #(
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_s,
  input  logic [NIB_W-1:0]  nib_s,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic              wr_grant,
  output logic              wr_req,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [WORD_W-1:0] wr_data,
  output logic              overflow
);
  localparam int NIBS = WORD_W / NIB_W;
  localparam int CW   = $clog2(NIBS);

  logic [CW-1:0]     cnt_q, cnt_n;
  logic [WORD_W-1:0] asm_q, asm_n, stage_q, stage_n;
  logic              pend_q, pend_n, ovf_q, ovf_n;
  logic              word_done, take;

  always_comb begin
    word_done = frame_s && (cnt_q == CW'(NIBS-1));
    take      = wr_grant && pend_q;
    asm_n     = asm_q;
    if (frame_s) asm_n[int'(cnt_q)*NIB_W +: NIB_W] = nib_s;
    cnt_n   = (load || !frame_s) ? '0 : cnt_q + 1'b1;
    stage_n = stage_q;
    pend_n  = pend_q;
    ovf_n   = ovf_q;
    if (load) begin
      pend_n = 1'b0;
      ovf_n  = 1'b0;
    end else begin
      if (take) pend_n = 1'b0;
      if (word_done) begin
        if (!pend_q || take) begin
          stage_n = asm_n;
          pend_n  = 1'b1;
        end else begin
          ovf_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt_q   <= '0;
      asm_q   <= '0;
      stage_q <= '0;
      pend_q  <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      pend_q <= pend_n;
      ovf_q  <= ovf_n;
      if (frame_s)   asm_q   <= asm_n;
      if (word_done) stage_q <= stage_n;
    end

  nwd_addr_ctr #(.AW(ADDR_W)) i_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(base),
    .inc(take && !load), .q(wr_addr)
  );

  assign wr_req   = pend_q;
  assign wr_data  = stage_q;
  assign overflow = ovf_q;

  p_req_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_req && !wr_grant && !load |=> wr_req && $stable(wr_data) && $stable(wr_addr));
  p_overflow_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overflow && !load |=> overflow);
  p_overflow_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(overflow) |-> $past(wr_req) && !$past(wr_grant));
  p_load_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> !overflow && !wr_req);
endmodule

// File: rtl/nwd_tx.sv
`timescale 1ns/1ps
module nwd_tx #(
  parameter int NIB_W  = 4,
  parameter int WORD_W = 16,
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] first,
  input  logic [ADDR_W-1:0] last,
  input  logic              rd_grant,
  input  logic [WORD_W-1:0] rd_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [NIB_W-1:0]  nib,
  output logic              en
);
  localparam int NIBS = WORD_W / NIB_W;
  localparam int CW   = $clog2(NIBS);

  logic              fetch_q, fetch_n;
  logic [ADDR_W-1:0] end_q, end_n;
  logic [WORD_W-1:0] cur_q, cur_n, pre_q, pre_n;
  logic              curv_q, curv_n, prev_q, prev_n;
  logic [CW-1:0]     cnt_q, cnt_n;
  logic              take, slot_free;

  always_comb begin
    rd_req    = fetch_q && !prev_q;
    take      = rd_grant && rd_req;
    slot_free = !curv_q || (cnt_q == CW'(NIBS-1));
    fetch_n = fetch_q;
    end_n   = end_q;
    cur_n   = cur_q;
    curv_n  = curv_q;
    pre_n   = pre_q;
    prev_n  = prev_q;
    cnt_n   = cnt_q;
    if (load) begin
      fetch_n = 1'b1;
      end_n   = last;
      curv_n  = 1'b0;
      prev_n  = 1'b0;
      cnt_n   = '0;
    end else begin
      if (take && rd_addr == end_q) fetch_n = 1'b0;
      if (curv_q) cnt_n = cnt_q + 1'b1;
      if (slot_free) begin
        cnt_n = '0;
        if (prev_q) begin
          cur_n  = pre_q;
          curv_n = 1'b1;
          prev_n = 1'b0;
        end else if (take) begin
          cur_n  = rd_data;
          curv_n = 1'b1;
        end else begin
          curv_n = 1'b0;
        end
      end else if (take) begin
        pre_n  = rd_data;
        prev_n = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      fetch_q <= 1'b0;
      end_q   <= '0;
      cur_q   <= '0;
      curv_q  <= 1'b0;
      pre_q   <= '0;
      prev_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      fetch_q <= fetch_n;
      curv_q  <= curv_n;
      prev_q  <= prev_n;
      cnt_q   <= cnt_n;
      if (load)      end_q <= end_n;
      if (slot_free) cur_q <= cur_n;
      if (take)      pre_q <= pre_n;
    end

  nwd_addr_ctr #(.AW(ADDR_W)) i_ctr (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(first),
    .inc(take && !load), .q(rd_addr)
  );

  assign nib = cur_q[int'(cnt_q)*NIB_W +: NIB_W];
  assign en  = curv_q;

  p_word_whole_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en && (cnt_q != CW'(NIBS-1)) && !load |=> en);
  p_prefetch_handoff_r10: assert property (@(posedge clk) disable iff (!rst_n)
    en && (cnt_q == CW'(NIBS-1)) && prev_q && !load |=> en && (cnt_q == '0));
  p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req && !rd_grant && !load |=> $stable(rd_addr));
  p_done_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_q && !en && !load |=> !rd_req && !en);
endmodule

// File: rtl/nwd_top.sv
`timescale 1ns/1ps
module nwd_top
  import nwd_pkg::*;
#(
  parameter int NIB_W  = NWD_NIB_W,
  parameter int WORD_W = NWD_WORD_W,
  parameter int ADDR_W = NWD_ADDR_W,
  parameter int SYNC   = NWD_SYNC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_frame,
  input  logic [NIB_W-1:0]  rx_nib,
  input  logic              rx_load,
  input  logic [ADDR_W-1:0] rx_base,
  input  logic              rx_wr_grant,
  output logic              rx_wr_req,
  output logic [ADDR_W-1:0] rx_wr_addr,
  output logic [WORD_W-1:0] rx_wr_data,
  output logic              rx_overflow,
  input  logic              tx_load,
  input  logic [ADDR_W-1:0] tx_first,
  input  logic [ADDR_W-1:0] tx_last,
  input  logic              tx_rd_grant,
  input  logic [WORD_W-1:0] tx_rd_data,
  output logic              tx_rd_req,
  output logic [ADDR_W-1:0] tx_rd_addr,
  output logic [NIB_W-1:0]  tx_nib,
  output logic              tx_en
);
  logic             rst_sync_n;
  logic             frame_s;
  logic [NIB_W-1:0] nib_s;

  nwd_delay_line #(.W(1), .STAGES(2)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .d(1'b1), .q(rst_sync_n)
  );
  nwd_delay_line #(.W(1), .STAGES(SYNC)) i_frame_sync (
    .clk(clk), .rst_n(rst_sync_n), .d(rx_frame), .q(frame_s)
  );
  nwd_delay_line #(.W(NIB_W), .STAGES(SYNC)) i_nib_align (
    .clk(clk), .rst_n(rst_sync_n), .d(rx_nib), .q(nib_s)
  );

  nwd_rx #(.NIB_W(NIB_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_rx (
    .clk(clk), .rst_n(rst_sync_n), .frame_s(frame_s), .nib_s(nib_s),
    .load(rx_load), .base(rx_base), .wr_grant(rx_wr_grant),
    .wr_req(rx_wr_req), .wr_addr(rx_wr_addr), .wr_data(rx_wr_data),
    .overflow(rx_overflow)
  );

  nwd_tx #(.NIB_W(NIB_W), .WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_tx (
    .clk(clk), .rst_n(rst_sync_n), .load(tx_load), .first(tx_first),
    .last(tx_last), .rd_grant(tx_rd_grant), .rd_data(tx_rd_data),
    .rd_req(tx_rd_req), .rd_addr(tx_rd_addr), .nib(tx_nib), .en(tx_en)
  );

  p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $rose(rst_sync_n) |-> !rx_wr_req && !tx_rd_req && !tx_en && !rx_overflow);
endmodule

// File: tb/test_nwd_top.sv
`timescale 1ns/1ps
module test_nwd_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        rx_frame, rx_load, rx_wr_grant, rx_wr_req, rx_overflow;
  logic [3:0]  rx_nib, tx_nib;
  logic [15:0] rx_base, rx_wr_addr, rx_wr_data;
  logic        tx_load, tx_rd_grant, tx_rd_req, tx_en;
  logic [15:0] tx_first, tx_last, tx_rd_data, tx_rd_addr;

  always #10 clk = ~clk;

  nwd_top i_nwd_top (.*);

  int n_chk = 0, n_fail = 0, phase = 0;
  bit rx_gnt_en = 0, live = 0, tx_busy = 0;
  logic [15:0] rx_exp_addr = '0;
  logic [31:0] rxq[$];
  logic [3:0]  txq[$];

  function automatic logic [15:0] mem_word(logic [15:0] a);
    return (a * 16'h03B5) ^ 16'hC3A1;
  endfunction

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic summary;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // slot arbiter, read memory model and receive monitor
  always @(negedge clk) begin
    phase = (phase + 1) % 4;
    rx_wr_grant = live && rx_gnt_en && (phase == 3) && rx_wr_req;
    if (rx_wr_grant) begin
      if (rxq.size() == 0) chk("R5", "unexpected write", {rx_wr_addr, rx_wr_data}, 32'h0);
      else begin
        logic [31:0] e;
        e = rxq.pop_front();
        chk("R4", "write address", {16'h0, rx_wr_addr}, {16'h0, e[31:16]});
        chk("R3", "write word", {16'h0, rx_wr_data}, {16'h0, e[15:0]});
      end
    end
    tx_rd_grant = live && (phase == 1) && tx_rd_req;
    tx_rd_data  = tx_rd_grant ? mem_word(tx_rd_addr) : 16'h0;
  end

  // transmit monitor
  always @(negedge clk) begin
    if (live) begin
      if (tx_en) begin
        if (txq.size() == 0) chk("R11", "nibble after packet end", {28'h0, tx_nib}, 32'h0);
        else chk("R9", "nibble", {28'h0, tx_nib}, {28'h0, txq.pop_front()});
        tx_busy = 1;
      end else if (tx_busy && txq.size() != 0) begin
        chk("R10", "gap in nibble stream", 32'h0, 32'h1);
      end
      if (txq.size() == 0) tx_busy = 0;
    end
  end

  task automatic rx_nibble(logic [3:0] n);
    @(negedge clk); rx_frame = 1'b1; rx_nib = n;
  endtask
  task automatic rx_end;
    @(negedge clk); rx_frame = 1'b0; rx_nib = 4'h0;
  endtask
  task automatic rx_word(logic [15:0] w);
    for (int i = 0; i < 4; i++) rx_nibble(w[i*4 +: 4]);
    rxq.push_back({rx_exp_addr, w});
    rx_exp_addr++;
  endtask
  task automatic rx_set_base(logic [15:0] a);
    @(negedge clk); rx_load = 1'b1; rx_base = a;
    @(negedge clk); rx_load = 1'b0;
    rx_exp_addr = a;
  endtask
  task automatic tx_packet(logic [15:0] f, logic [15:0] l);
    @(negedge clk); tx_load = 1'b1; tx_first = f; tx_last = l;
    for (logic [16:0] a = {1'b0, f}; a <= {1'b0, l}; a++)
      for (int k = 0; k < 4; k++) txq.push_back(mem_word(a[15:0])[k*4 +: 4]);
    @(negedge clk); tx_load = 1'b0;
  endtask
  task automatic tx_drain(logic [15:0] end_addr);
    for (int i = 0; i < 400 && txq.size() != 0; i++) @(negedge clk);
    repeat (4) @(negedge clk);
    chk("R9", "all nibbles sent", txq.size(), 32'h0);
    chk("R11", "tx_en idle", {31'h0, tx_en}, 32'h0);
    chk("R11", "tx_rd_req idle", {31'h0, tx_rd_req}, 32'h0);
    chk("R8", "final read address", {16'h0, tx_rd_addr}, {16'h0, end_addr});
  endtask

  initial begin
    #(20 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual running expected finished");
    summary();
    $finish;
  end

  initial begin
    logic [15:0] w1, w2;
    rst_n = 1'b0; rx_frame = 0; rx_nib = 0; rx_load = 0; rx_base = 0;
    tx_load = 0; tx_first = 0; tx_last = 0;
    repeat (3) @(negedge clk);
    chk("R1", "rx_wr_req in reset", {31'h0, rx_wr_req}, 32'h0);
    chk("R1", "tx_rd_req in reset", {31'h0, tx_rd_req}, 32'h0);
    chk("R1", "tx_en in reset", {31'h0, tx_en}, 32'h0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    live = 1;
    chk("R1", "rx_overflow after reset", {31'h0, rx_overflow}, 32'h0);
    chk("R1", "rx_wr_addr after reset", {16'h0, rx_wr_addr}, 32'h0);
    chk("R1", "tx_rd_addr after reset", {16'h0, tx_rd_addr}, 32'h0);

    // R2, R5: held write, latency, overflow
    rx_set_base(16'h0100);
    rx_gnt_en = 0;
    w1 = 16'hB7E2; w2 = 16'h4D19;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (k == 5) chk("R2", "request not yet raised", {31'h0, rx_wr_req}, 32'h0);
      if (k == 6) chk("R2", "request raised", {31'h0, rx_wr_req}, 32'h1);
      rx_frame = 1'b1;
      rx_nib = (k < 4) ? w1[k*4 +: 4] : w2[(k-4)*4 +: 4];
    end
    rxq.push_back({16'h0100, w1});
    rx_exp_addr = 16'h0101;
    rx_end();
    repeat (6) @(negedge clk);
    chk("R5", "overflow raised", {31'h0, rx_overflow}, 32'h1);
    chk("R4", "request held", {31'h0, rx_wr_req}, 32'h1);
    chk("R4", "address held", {16'h0, rx_wr_addr}, 32'h0100);
    chk("R5", "older word kept", {16'h0, rx_wr_data}, {16'h0, w1});
    rx_gnt_en = 1;
    repeat (8) @(negedge clk);
    chk("R5", "dropped word not requested", {31'h0, rx_wr_req}, 32'h0);
    chk("R4", "address advanced", {16'h0, rx_wr_addr}, 32'h0101);
    chk("R5", "overflow sticky", {31'h0, rx_overflow}, 32'h1);
    rx_set_base(16'h0200);
    chk("R7", "overflow cleared", {31'h0, rx_overflow}, 32'h0);
    chk("R7", "base loaded", {16'h0, rx_wr_addr}, 32'h0200);

    // R6: partial word discarded, then aligned back-to-back words
    rx_nibble(4'h1); rx_nibble(4'h2); rx_end();
    repeat (6) @(negedge clk);
    chk("R6", "partial word gives no request", {31'h0, rx_wr_req}, 32'h0);
    rx_word(16'h8C35); rx_word(16'hF00D); rx_word(16'h1234);
    rx_end();
    repeat (12) @(negedge clk);
    chk("R4", "all writes granted", rxq.size(), 32'h0);
    chk("R4", "no overflow back to back", {31'h0, rx_overflow}, 32'h0);

    // R8-R11: transmit packets
    tx_packet(16'h0010, 16'h0013);
    tx_drain(16'h0014);
    tx_packet(16'h00FF, 16'h00FF);
    tx_drain(16'h0100);
    fork
      tx_packet(16'h0030, 16'h0037);
      begin
        rx_set_base(16'h0300);
        rx_word(16'h0F1E); rx_word(16'h2D3C); rx_word(16'h4B5A); rx_word(16'h6978);
        rx_end();
      end
    join
    tx_drain(16'h0038);
    repeat (10) @(negedge clk);
    chk("R4", "concurrent writes granted", rxq.size(), 32'h0);
    chk("R4", "concurrent final address", {16'h0, rx_wr_addr}, 32'h0304);

    summary();
    $finish;
  end
endmodule